// File: doc/BRIEF.md
# Multi-Lane Receive Aligner

This block is the receive front end of a serial link with several lanes. Each lane arrives as a byte stream with a valid strobe. The block latches the link configuration while training is still running. That configuration covers the local and partner lane counts, the local and partner rate capabilities, a per-lane polarity swap mask and a lane-reversal flag. From it the block derives the operating width and the link rate code. It then freezes that configuration for as long as training stays complete.

With training complete, the block does four things to the data:

- It corrects the polarity of each lane.
- It hunts for the alignment symbol (byte value 0xBC) on every active lane.
- It holds the earlier lanes in small elastic buffers until the latest lane catches up.
- It releases all active lanes together as one wide word, with the logical lane order reversed when requested.

Lanes outside the operating width play no part in any of this and read as zero.

Top module: `lane_rx_align`

## Requirements
- R1: While `train_done` is low, each clock edge latches the configuration. `link_width` then shows min(`local_lanes`, `partner_lanes`), clamped to the lane count NL (4). It is visible after that edge.
- R2: `link_rate` uses the rate bit masks, where bit0 = base rate, bit1 = second rate and bit2 = third rate. It is 2 if both masks have bit2 set, else 1 if both have bit1 set, else 0.
- R3: While `train_done` is high, `link_width`, `link_rate`, the polarity mask and the reversal flag hold their values whatever the configuration inputs do.
- R4: A lane whose `invert_en` bit was latched set has every received byte bit-inverted. This happens before the alignment symbol 0xBC is detected and before the byte is output.
- R5: The alignment symbol is 0xBC, and `rx_valid` is held high on the active lanes. Let the last active lane's symbol be sampled at edge E. After edge E+1, `aligned` and `out_valid` are high and every active output lane shows 0xBC. Each following edge outputs the next byte of every lane in step.
- R6: If the active lanes' symbols are up to 7 cycles apart, they are aligned. Let the first symbol be sampled at edge E0. If any active lane has still not shown its symbol by edge E0+7, `deskew_err` pulses for exactly the one cycle after E0+7 and the hunt restarts from empty buffers.
- R7: With reversal latched, logical output lane j (byte j of `out_data`) carries physical lane `link_width`-1-j. Without reversal, it carries physical lane j.
- R8: Lanes numbered at or above `link_width` are ignored. Their bytes, including any 0xBC, affect neither alignment nor errors, and their output bytes are always zero.
- R9: During reset, `link_width`, `link_rate`, `aligned`, `deskew_err`, `out_valid` and `out_data` are all zero.
- R10: While `train_done` is low, no alignment happens. `aligned` and `out_valid` are low after every edge at which `train_done` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| train_done | input | 1 | Low: latch configuration. High: freeze it and run alignment |
| local_lanes | input | 3 | Lane count of this port |
| partner_lanes | input | 3 | Lane count of the link partner |
| local_rates | input | 3 | Rate capability mask of this port |
| partner_rates | input | 3 | Rate capability mask of the partner |
| reverse_en | input | 1 | Reverse the logical lane order |
| invert_en | input | 4 | Per-lane polarity swap |
| rx_data | input | 32 | Received bytes, lane i in bits 8i+7..8i |
| rx_valid | input | 4 | Per-lane byte strobe |
| link_width | output | 3 | Operating lane count |
| link_rate | output | 2 | Negotiated rate code |
| aligned | output | 1 | Lanes deskewed and streaming |
| deskew_err | output | 1 | One-cycle pulse on skew window overrun |
| out_valid | output | 1 | Aligned word valid |
| out_data | output | 32 | Aligned bytes, logical lane j in bits 8j+7..8j |

## Verification
Configuration results (width and rate) are due one edge after they are presented with `train_done` low. Aligned data is due two edges after the last active lane's symbol: one edge to write the buffer and one to register the output. A skew error is due at the seventh edge after the first symbol. The bench drives inputs on the falling edge and reads results one time unit after the rising edge at which each is due. Each scenario task counts edges from its first driven beat, so every comparison names the exact beat it expects.

// File: rtl/lane_rx_align.sv
module lane_rx_align #(
  parameter int NL = 4,
  parameter int DW = 8,
  parameter int FD = 8,
  parameter logic [7:0] MARK = 8'hBC,
  parameter int WW = $clog2(NL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            train_done,
  input  logic [WW-1:0]   local_lanes,
  input  logic [WW-1:0]   partner_lanes,
  input  logic [2:0]      local_rates,
  input  logic [2:0]      partner_rates,
  input  logic            reverse_en,
  input  logic [NL-1:0]   invert_en,
  input  logic [NL*DW-1:0] rx_data,
  input  logic [NL-1:0]   rx_valid,
  output logic [WW-1:0]   link_width,
  output logic [1:0]      link_rate,
  output logic            aligned,
  output logic            deskew_err,
  output logic            out_valid,
  output logic [NL*DW-1:0] out_data
);
  localparam int PW = (FD > 1) ? $clog2(FD) : 1;
  localparam int CW = $clog2(FD + 1);

  logic [WW-1:0] wmin, wclamp;
  logic [1:0]    rate_nx;
  logic          rev_q;
  logic [NL-1:0] inv_q;

  assign wmin    = (local_lanes < partner_lanes) ? local_lanes : partner_lanes;
  assign wclamp  = (wmin > WW'(NL)) ? WW'(NL) : wmin;
  assign rate_nx = (local_rates[2] & partner_rates[2]) ? 2'd2 :
                   (local_rates[1] & partner_rates[1]) ? 2'd1 : 2'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      link_width <= '0;
      link_rate  <= '0;
      rev_q      <= 1'b0;
      inv_q      <= '0;
    end else if (!train_done) begin
      link_width <= wclamp;
      link_rate  <= rate_nx;
      rev_q      <= reverse_en;
      inv_q      <= invert_en;
    end

  logic [NL-1:0] active, hit, push, full, nemp;
  logic [NL-1:0] seen;
  logic [CW-1:0] win;
  logic [DW-1:0] fixed [NL];
  logic [DW-1:0] head  [NL];
  logic          all_seen, pop, ovf, tmo, err, flush;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [DW-1:0] mem [FD];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] fill;
    logic          wr, rd;

    assign active[i] = (i < int'(link_width));
    assign fixed[i]  = rx_data[i*DW +: DW] ^ {DW{inv_q[i]}};
    assign hit[i]    = active[i] & rx_valid[i] & (fixed[i] == MARK);
    assign push[i]   = active[i] & rx_valid[i] & (aligned | seen[i] | hit[i]);
    assign full[i]   = (fill == CW'(FD));
    assign nemp[i]   = (fill != '0);
    assign rd        = pop & active[i];
    assign wr        = push[i] & (!full[i] | rd);
    assign head[i]   = mem[rp];

    always_ff @(posedge clk)
      if (wr && !flush) mem[wp] <= fixed[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp <= '0; rp <= '0; fill <= '0;
      end else if (flush) begin
        wp <= '0; rp <= '0; fill <= '0;
      end else begin
        if (wr) wp <= (wp == PW'(FD - 1)) ? '0 : wp + 1'b1;
        if (rd) rp <= (rp == PW'(FD - 1)) ? '0 : rp + 1'b1;
        fill <= fill + CW'(wr) - CW'(rd);
      end

    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(FD));
  end

  assign all_seen = (active != '0) && (((seen | hit) & active) == active);
  assign pop      = train_done & aligned & (active != '0) & ((nemp | ~active) == '1);
  assign ovf      = aligned & !pop & ((push & full) != '0);
  assign tmo      = !aligned & (seen != '0) & !all_seen & (win == CW'(FD - 1));
  assign err      = train_done & (ovf | tmo);
  assign flush    = !train_done | err;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen <= '0; win <= '0; aligned <= 1'b0; deskew_err <= 1'b0;
    end else begin
      deskew_err <= err;
      if (flush) begin
        seen <= '0; win <= '0; aligned <= 1'b0;
      end else if (!aligned) begin
        if (all_seen) begin
          aligned <= 1'b1; seen <= '0; win <= '0;
        end else begin
          seen <= seen | hit;
          if (seen != '0) win <= win + 1'b1;
          else if (hit != '0) win <= CW'(1);
        end
      end
    end

  logic [NL*DW-1:0] mapped;
  always_comb begin
    mapped = '0;
    for (int j = 0; j < NL; j++)
      if (j < int'(link_width))
        mapped[j*DW +: DW] = head[rev_q ? (int'(link_width) - 1 - j) : j];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= pop;
      out_data  <= pop ? mapped : '0;
    end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  a_r1_width_min: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!train_done) |-> link_width <= WW'(NL) &&
    link_width <= $past(local_lanes) && link_width <= $past(partner_lanes));
  a_r2_rate_code: assert property (@(posedge clk) disable iff (!rst_n)
    link_rate != 2'd3);
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && train_done && $past(train_done) |-> $stable(link_width) && $stable(link_rate));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !train_done |=> !aligned && !out_valid);
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    deskew_err |=> !deskew_err);
  a_r5_valid_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(aligned));
endmodule

// File: tb/lane_rx_align_tb.sv
module lane_rx_align_tb;
  logic clk = 0, rst_n = 0, train_done = 0;
  logic [2:0] local_lanes = 4, partner_lanes = 4, local_rates = 1, partner_rates = 1;
  logic reverse_en = 0;
  logic [3:0] invert_en = 0, rx_valid = 4'hF;
  logic [31:0] rx_data = 0;
  logic [2:0] link_width;
  logic [1:0] link_rate;
  logic aligned, deskew_err, out_valid;
  logic [31:0] out_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_rx_align u_dut (.clk, .rst_n, .train_done, .local_lanes, .partner_lanes,
    .local_rates, .partner_rates, .reverse_en, .invert_en, .rx_data, .rx_valid,
    .link_width, .link_rate, .aligned, .deskew_err, .out_valid, .out_data);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic setup(int ll, int pl, int lr, int pr, bit rev, logic [3:0] inv);
    @(negedge clk);
    train_done = 0; rx_data = 0;
    local_lanes = 3'(ll); partner_lanes = 3'(pl);
    local_rates = 3'(lr); partner_rates = 3'(pr);
    reverse_en = rev; invert_en = inv;
    step();
    @(negedge clk);
    train_done = 1;
  endtask

  function automatic logic [7:0] lane_byte(int lane, int seq);
    if (seq < 0) return 8'h00;
    if (seq == 0) return 8'hBC;
    return 8'(16 * lane + seq);
  endfunction

  // streams markers at given skews; width w; inactive lanes send 0xBC noise
  task automatic run_align(string req, int w, bit rev, logic [3:0] inv, int sk[4], int beats);
    int mx = 0;
    for (int i = 0; i < w; i++) if (sk[i] > mx) mx = sk[i];
    for (int c = 0; c <= mx + beats; c++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        logic [7:0] b;
        b = (i < w) ? lane_byte(i, c - sk[i]) : ((c % 2) ? 8'hBC : 8'h5A);
        if (inv[i]) b = ~b;
        rx_data[i*8 +: 8] = b;
      end
      step();
      if (c >= mx + 1) begin
        logic [31:0] exp = 0;
        int k = c - mx - 1;
        for (int j = 0; j < w; j++) begin
          int src = rev ? (w - 1 - j) : j;
          exp[j*8 +: 8] = lane_byte(src, k);
        end
        chk({req, " data"}, out_data, exp);
        chk({req, " valid"}, {30'b0, aligned, out_valid}, 32'h3);
      end else begin
        chk({req, " not yet valid"}, {31'b0, out_valid}, 0);
      end
    end
  endtask

  task automatic t_reset();
    chk("R9 width", {29'b0, link_width}, 0);
    chk("R9 rate", {30'b0, link_rate}, 0);
    chk("R9 flags", {29'b0, aligned, deskew_err, out_valid}, 0);
    chk("R9 data", out_data, 0);
  endtask

  task automatic t_config();
    int combos[5][4] = '{'{2,4,7,3}, '{4,2,7,7}, '{4,4,3,1}, '{1,3,6,6}, '{7,6,2,3}};
    foreach (combos[n]) begin
      int ll = combos[n][0], pl = combos[n][1], lr = combos[n][2], pr = combos[n][3];
      int m = (ll < pl) ? ll : pl;
      int er;
      if (m > 4) m = 4;
      er = ((lr & pr & 4) != 0) ? 2 : ((lr & pr & 2) != 0) ? 1 : 0;
      setup(ll, pl, lr, pr, 0, 0);
      chk("R1 width min", {29'b0, link_width}, 32'(m));
      chk("R2 rate", {30'b0, link_rate}, 32'(er));
    end
  endtask

  task automatic t_frozen();
    setup(2, 4, 7, 7, 0, 0);
    @(negedge clk);
    local_lanes = 1; partner_lanes = 1; local_rates = 1; partner_rates = 1;
    step(); step();
    chk("R3 width frozen", {29'b0, link_width}, 2);
    chk("R3 rate frozen", {30'b0, link_rate}, 2);
  endtask

  task automatic t_idle();
    @(negedge clk);
    train_done = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      rx_data = (c < 2) ? 32'h0 : 32'hBCBCBCBC;
      step();
      if (c == 11) chk("R10 idle", {30'b0, aligned, out_valid}, 0);
    end
  endtask

  task automatic t_timeout();
    setup(2, 2, 1, 1, 0, 0);
    for (int c = 0; c < 9; c++) begin
      @(negedge clk);
      rx_data = 0;
      rx_data[7:0]  = (c == 0) ? 8'hBC : 8'h01;
      rx_data[15:8] = (c == 8) ? 8'hBC : 8'h02;
      step();
      if (c == 6) chk("R6 no err before window end", {31'b0, deskew_err}, 0);
      if (c == 7) chk("R6 err at window end", {30'b0, deskew_err, aligned}, 2);
      if (c == 8) chk("R6 err one cycle", {30'b0, deskew_err, out_valid}, 0);
    end
  endtask

  initial begin
    int s0[4] = '{0, 0, 0, 0};
    int s1[4] = '{3, 0, 5, 1};
    int s7[4] = '{7, 0, 0, 2};
    int s2[4] = '{0, 4, 0, 0};
    #7; t_reset();
    rst_n = 1;
    t_config();
    t_frozen();
    setup(4, 4, 1, 1, 0, 0);
    run_align("R5 zero skew", 4, 0, 0, s0, 4);
    setup(4, 4, 1, 1, 0, 0);
    run_align("R5 mixed skew", 4, 0, 0, s1, 5);
    setup(4, 4, 1, 1, 0, 0);
    run_align("R6 max skew 7", 4, 0, 0, s7, 3);
    setup(4, 4, 1, 1, 0, 4'b0110);
    run_align("R4 polarity", 4, 0, 4'b0110, s1, 3);
    setup(4, 4, 1, 1, 1, 0);
    run_align("R7 reversed x4", 4, 1, 0, s1, 3);
    setup(2, 4, 1, 1, 1, 0);
    run_align("R7 R8 reversed x2", 2, 1, 0, s2, 3);
    setup(4, 2, 1, 1, 0, 0);
    run_align("R8 inactive lanes", 2, 0, 0, s2, 3);
    t_timeout();
    setup(2, 2, 1, 1, 0, 0);
    run_align("R6 recovery", 2, 0, 0, s2, 2);
    t_idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule